// File: doc/BRIEF.md
# Dual-Clock Burst-Addressed Dual-Port RAM

This block is a two-port synchronous memory. Its left and right ports are identical and each runs on its own clock. Each port can reach any word of one shared array.

Each port has a burst address register of its own. Three active-low controls update it at every clock edge:
- a clear forces it to zero;
- a strobe loads it from the port's address input;
- a step advances it by one.

The access in that cycle uses the address that the register takes on. Software, or a DMA engine, can therefore issue one address and then walk through consecutive words without presenting new addresses.

Every port has the following controls:
- a two-line chip select;
- a write-enable;
- an output enable that gates read data;
- a mode input that picks between two read latencies:
  - flow-through: data is visible right after the sampling edge;
  - pipelined: data arrives one edge later.

Depth (as an address width) and word width are parameters.

Top module: `dpb_burst_ram`

## Requirements
- R1: While clear_n is low at an edge, the port's burst register becomes 0 and the access uses address 0, whatever strobe_n and step_n are doing.
- R2: When clear_n is high and strobe_n is low at an edge, the burst register is loaded from addr and the access uses addr.
- R3: When clear_n and strobe_n are both high, step_n low at an edge advances the burst register by one, and the access uses the advanced value. With all three controls high, the register holds and the access reuses it. In any cycle where clear_n or strobe_n is low, step_n has no effect.
- R4: Stepping from address 2^AW-1 wraps the burst register to 0.
- R5: A port is selected only when sel0_n is 0 and sel1 is 1. An unselected cycle writes nothing and produces no read data.
- R6: On a selected cycle, we_n low stores wdata at the access address, and we_n high reads that address.
- R7: While oe_n is high, rvalid is 0 and rdata is all zeros.
- R8: With pipe low, a read sampled at edge k shows rvalid=1 and its data from edge k until edge k+1.
- R9: With pipe high, a read sampled at edge k shows its data from edge k+1 until edge k+2.
- R10: A port whose clock is stopped keeps its burst register and its memory contents, whatever its inputs do.
- R11: If both ports write the same address in the same cycle, the left value is stored. A read by one port of an address that the other port writes in the same cycle returns either the old or the new word.
- R12: A synchronous active-high rst clears that port's burst register to 0 and drops its rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left clock |
| l_rst | input | 1 | Left synchronous reset, active high |
| l_sel0_n | input | 1 | Left select, active low |
| l_sel1 | input | 1 | Left select, active high |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_strobe_n | input | 1 | Left address load, active low |
| l_step_n | input | 1 | Left burst advance, active low |
| l_clear_n | input | 1 | Left burst clear, active low |
| l_pipe | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| l_addr | input | AW | Left external address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid (stands for the output drivers being on) |
| r_clk | input | 1 | Right clock |
| r_rst | input | 1 | Right synchronous reset, active high |
| r_sel0_n | input | 1 | Right select, active low |
| r_sel1 | input | 1 | Right select, active high |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_strobe_n | input | 1 | Right address load, active low |
| r_step_n | input | 1 | Right burst advance, active low |
| r_clear_n | input | 1 | Right burst clear, active low |
| r_pipe | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| r_addr | input | AW | Right external address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is within one port: a burst-register clear or load and a step. The bench raises strobe together with step, and clear together with strobe and step. It then issues a read with no controls active, which shows from the data which address the register kept.

The second pair is across the ports: writes to one address. The bench runs both clocks in phase and lets both ports write one address on the same edge. It then reads the word back and expects the left value. A same-cycle write and read of one word across the ports is also provoked, and the bench accepts either the old or the new word.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_LOAD,
    ACT_CLEAR
  } burst_act_e;

  // clear beats load, load beats step
  function automatic burst_act_e pick_act(input logic clr_n, input logic stb_n,
                                          input logic step_n);
    if (!clr_n)       return ACT_CLEAR;
    else if (!stb_n)  return ACT_LOAD;
    else if (!step_n) return ACT_STEP;
    else              return ACT_HOLD;
  endfunction

endpackage

// File: rtl/dpb_burst_ctr.sv
module dpb_burst_ctr
  import dpb_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          stb_n,
  input  logic          step_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic [AW-1:0] cnt
);

  burst_act_e    act;
  logic [AW-1:0] cnt_q;

  always_comb begin
    act = pick_act(clr_n, stb_n, step_n);
    unique case (act)
      ACT_CLEAR: acc_addr = '0;
      ACT_LOAD:  acc_addr = ext_addr;
      ACT_STEP:  acc_addr = cnt_q + AW'(1);
      default:   acc_addr = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= acc_addr;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/dpb_store.sv
module dpb_store #(
  parameter int AW = 15,
  parameter int DW = 9
) (
  input  logic          a_clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_word,
  input  logic          b_clk,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_word
);

  localparam int DEPTH = 1 << AW;

  // one bank per writer; a pair of live bits per word names the newest bank
  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];
  logic          live_a [DEPTH];
  logic          live_b [DEPTH];

  logic          b_we_eff;
  logic [DW-1:0] a_ra, a_rb, b_ra, b_rb;
  logic          a_la, a_lb, b_la, b_lb;

  // same word written by both in the same cycle: side A keeps it
  assign b_we_eff = b_we && !(a_we && (a_addr == b_addr));

  always_ff @(posedge a_clk) begin
    if (a_we) begin
      bank_a[a_addr] <= a_wdata;
      live_a[a_addr] <= ~live_b[a_addr];
    end
    a_ra <= bank_a[a_addr];
    a_rb <= bank_b[a_addr];
    a_la <= live_a[a_addr];
    a_lb <= live_b[a_addr];
  end

  always_ff @(posedge b_clk) begin
    if (b_we_eff) begin
      bank_b[b_addr] <= b_wdata;
      live_b[b_addr] <= live_a[b_addr];
    end
    b_ra <= bank_a[b_addr];
    b_rb <= bank_b[b_addr];
    b_la <= live_a[b_addr];
    b_lb <= live_b[b_addr];
  end

  assign a_word = (a_la ^ a_lb) ? a_ra : a_rb;
  assign b_word = (b_la ^ b_lb) ? b_ra : b_rb;

endmodule

// File: rtl/dpb_rd_stage.sv
module dpb_rd_stage #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          pipe,
  input  logic          oe_n,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic          v1_q, v2_q;
  logic [DW-1:0] d2_q;
  logic          stage_v;
  logic [DW-1:0] stage_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= fire;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) d2_q <= word;

  always_comb begin
    stage_v = pipe ? v2_q : v1_q;
    stage_d = pipe ? d2_q : word;
    rvalid  = stage_v && !oe_n;
    rdata   = rvalid ? stage_d : '0;
  end

endmodule

// File: rtl/dpb_burst_ram.sv
module dpb_burst_ram #(
  parameter int AW = 15,
  parameter int DW = 9
) (
  input  logic          l_clk,
  input  logic          l_rst,
  input  logic          l_sel0_n,
  input  logic          l_sel1,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic          l_strobe_n,
  input  logic          l_step_n,
  input  logic          l_clear_n,
  input  logic          l_pipe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  input  logic          r_clk,
  input  logic          r_rst,
  input  logic          r_sel0_n,
  input  logic          r_sel1,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic          r_strobe_n,
  input  logic          r_step_n,
  input  logic          r_clear_n,
  input  logic          r_pipe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid
);

  logic [AW-1:0] l_acc, r_acc, l_cnt, r_cnt;
  logic          l_sel, r_sel, l_wr, r_wr, l_rd, r_rd;
  logic [DW-1:0] l_word, r_word;

  assign l_sel = !l_sel0_n && l_sel1;
  assign r_sel = !r_sel0_n && r_sel1;
  assign l_wr  = l_sel && !l_we_n;
  assign r_wr  = r_sel && !r_we_n;
  assign l_rd  = l_sel && l_we_n;
  assign r_rd  = r_sel && r_we_n;

  dpb_burst_ctr #(.AW(AW)) u_lctr (
    .clk(l_clk), .rst(l_rst), .clr_n(l_clear_n), .stb_n(l_strobe_n),
    .step_n(l_step_n), .ext_addr(l_addr), .acc_addr(l_acc), .cnt(l_cnt)
  );

  dpb_burst_ctr #(.AW(AW)) u_rctr (
    .clk(r_clk), .rst(r_rst), .clr_n(r_clear_n), .stb_n(r_strobe_n),
    .step_n(r_step_n), .ext_addr(r_addr), .acc_addr(r_acc), .cnt(r_cnt)
  );

  dpb_store #(.AW(AW), .DW(DW)) u_store (
    .a_clk(l_clk), .a_we(l_wr), .a_addr(l_acc), .a_wdata(l_wdata), .a_word(l_word),
    .b_clk(r_clk), .b_we(r_wr), .b_addr(r_acc), .b_wdata(r_wdata), .b_word(r_word)
  );

  dpb_rd_stage #(.DW(DW)) u_lrd (
    .clk(l_clk), .rst(l_rst), .fire(l_rd), .pipe(l_pipe), .oe_n(l_oe_n),
    .word(l_word), .rdata(l_rdata), .rvalid(l_rvalid)
  );

  dpb_rd_stage #(.DW(DW)) u_rrd (
    .clk(r_clk), .rst(r_rst), .fire(r_rd), .pipe(r_pipe), .oe_n(r_oe_n),
    .word(r_word), .rdata(r_rdata), .rvalid(r_rvalid)
  );

endmodule

// File: rtl/dpb_checker.sv
module dpb_checker #(
  parameter int AW = 15,
  parameter int DW = 9
) (
  input logic          l_clk,
  input logic          l_rst,
  input logic          l_clear_n,
  input logic          l_strobe_n,
  input logic          l_step_n,
  input logic          l_pipe,
  input logic          l_oe_n,
  input logic          l_rd,
  input logic          l_rvalid,
  input logic [AW-1:0] l_addr,
  input logic [AW-1:0] l_cnt,
  input logic          r_clk,
  input logic          r_rst,
  input logic          r_clear_n,
  input logic [AW-1:0] r_cnt
);

  AST_CLEAR_ZERO: assert property (@(posedge l_clk) disable iff (l_rst)
    !l_clear_n |=> (l_cnt == '0)); // R1

  AST_CLEAR_ZERO_RIGHT: assert property (@(posedge r_clk) disable iff (r_rst)
    !r_clear_n |=> (r_cnt == '0)); // R1

  AST_STROBE_LOAD: assert property (@(posedge l_clk) disable iff (l_rst)
    (l_clear_n && !l_strobe_n) |=> (l_cnt == $past(l_addr))); // R2

  AST_STEP_ADVANCE: assert property (@(posedge l_clk) disable iff (l_rst)
    (l_clear_n && l_strobe_n && !l_step_n) |=> (l_cnt == $past(l_cnt) + AW'(1))); // R3

  AST_IDLE_HOLD: assert property (@(posedge l_clk) disable iff (l_rst)
    (l_clear_n && l_strobe_n && l_step_n) |=> $stable(l_cnt)); // R3

  AST_FLOW_LATENCY: assert property (@(posedge l_clk) disable iff (l_rst)
    (!l_pipe && !l_oe_n && !$past(l_rst)) |-> (l_rvalid == $past(l_rd))); // R8

  AST_PIPE_LATENCY: assert property (@(posedge l_clk) disable iff (l_rst)
    (l_pipe && !l_oe_n && !$past(l_rst) && !$past(l_rst, 2))
      |-> (l_rvalid == $past(l_rd, 2))); // R9

endmodule

bind dpb_burst_ram dpb_checker #(.AW(AW), .DW(DW)) u_chk (
  .l_clk(l_clk), .l_rst(l_rst), .l_clear_n(l_clear_n), .l_strobe_n(l_strobe_n),
  .l_step_n(l_step_n), .l_pipe(l_pipe), .l_oe_n(l_oe_n), .l_rd(l_rd),
  .l_rvalid(l_rvalid), .l_addr(l_addr), .l_cnt(l_cnt),
  .r_clk(r_clk), .r_rst(r_rst), .r_clear_n(r_clear_n), .r_cnt(r_cnt)
);

// File: tb/dpb_burst_ram_bench.sv
`timescale 1ns/1ps
module dpb_burst_ram_bench;
  localparam int AW = 15;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic l_clk = 1'b0, r_run = 1'b1;
  logic r_clk;
  logic l_rst, l_sel0_n, l_sel1, l_we_n, l_oe_n, l_strobe_n, l_step_n, l_clear_n, l_pipe;
  logic r_rst, r_sel0_n, r_sel1, r_we_n, r_oe_n, r_strobe_n, r_step_n, r_clear_n, r_pipe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rvalid, r_rvalid;

  always #2.5 l_clk = ~l_clk;
  assign r_clk = l_clk & r_run;

  dpb_burst_ram #(.AW(AW), .DW(DW)) u_dpb_burst_ram (.*);

  int vectors = 0, errors = 0;
  string tag = "R12";
  bit done = 0;

  // behavioural reference
  int mem [int];
  int lcnt, rcnt;
  bit lv1, lv2, rv1, rv2;
  int ld1, ld2, la1, la2, rd1, rd2, ra1, ra2;

  function automatic int mget(int a);
    return mem.exists(a) ? mem[a] : 0;
  endfunction

  function automatic int next_addr(int cnt, logic clrn, logic stbn, logic stepn, int ext);
    if (!clrn)      return 0;
    else if (!stbn) return ext;
    else if (!stepn) return (cnt + 1) % DEPTH;
    else            return cnt;
  endfunction

  always @(posedge l_clk) begin
    int lea, rea, lold, rold;
    bit lsel, rsel, lwr, rwr, lrd, rrd;
    lea = next_addr(lcnt, l_clear_n, l_strobe_n, l_step_n, int'(l_addr));
    rea = next_addr(rcnt, r_clear_n, r_strobe_n, r_step_n, int'(r_addr));
    lsel = !l_sel0_n && l_sel1;
    rsel = r_run && !r_sel0_n && r_sel1;
    lwr = lsel && !l_we_n;  lrd = lsel && l_we_n;
    rwr = rsel && !r_we_n;  rrd = rsel && r_we_n;
    lold = mget(lea);
    rold = mget(rea);
    if (l_rst) begin
      lcnt = 0; lv1 = 0; lv2 = 0;
    end else begin
      lcnt = lea;
      lv2 = lv1; ld2 = ld1; la2 = la1;
      lv1 = lrd; ld1 = lold;
      la1 = (rwr && rea == lea && !(lwr && lea == rea)) ? int'(r_wdata) : lold;
    end
    if (r_run) begin
      if (r_rst) begin
        rcnt = 0; rv1 = 0; rv2 = 0;
      end else begin
        rcnt = rea;
        rv2 = rv1; rd2 = rd1; ra2 = ra1;
        rv1 = rrd; rd1 = rold;
        ra1 = (lwr && lea == rea) ? int'(l_wdata) : rold;
      end
    end
    if (lwr && !l_rst) mem[lea] = int'(l_wdata);
    if (rwr && !r_rst && !(lwr && !l_rst && lea == rea)) mem[rea] = int'(r_wdata);
  end

  task automatic cmp(string side, logic oen, logic pipe, bit v1, bit v2, int d1, int d2,
                     int a1, int a2, logic gv, logic [DW-1:0] gd);
    bit ev;
    int ed, ea;
    ev = !oen && (pipe ? v2 : v1);
    ed = pipe ? d2 : d1;
    ea = pipe ? a2 : a1;
    vectors++;
    if (gv !== ev || (ev && int'(gd) != ed && int'(gd) != ea) || (!ev && gd !== '0)) begin
      errors++;
      $display("FAIL %s %s port: rvalid=%0b rdata=%0h expected rvalid=%0b rdata=%0h (or %0h)",
               tag, side, gv, gd, ev, ev ? ed : 0, ev ? ea : 0);
    end
  endtask

  task automatic tick();
    @(posedge l_clk);
    @(negedge l_clk);
    cmp("left", l_oe_n, l_pipe, lv1, lv2, ld1, ld2, la1, la2, l_rvalid, l_rdata);
    cmp("right", r_oe_n, r_pipe, rv1, rv2, rd1, rd2, ra1, ra2, r_rvalid, r_rdata);
  endtask

  task automatic ldrv(bit sel, bit wr, bit stb, bit step, bit clr, int a, int d);
    l_sel0_n = !sel; l_sel1 = 1'b1; l_we_n = !wr; l_strobe_n = !stb;
    l_step_n = !step; l_clear_n = !clr; l_addr = AW'(a); l_wdata = DW'(d);
  endtask

  task automatic rdrv(bit sel, bit wr, bit stb, bit step, bit clr, int a, int d);
    r_sel0_n = !sel; r_sel1 = 1'b1; r_we_n = !wr; r_strobe_n = !stb;
    r_step_n = !step; r_clear_n = !clr; r_addr = AW'(a); r_wdata = DW'(d);
  endtask

  initial begin
    l_rst = 1; r_rst = 1; l_oe_n = 0; r_oe_n = 0; l_pipe = 0; r_pipe = 0;
    ldrv(0, 0, 0, 0, 0, 0, 0);
    rdrv(0, 0, 0, 0, 0, 0, 0);
    lcnt = 0; rcnt = 0; lv1 = 0; lv2 = 0; rv1 = 0; rv2 = 0;
    ld1 = 0; ld2 = 0; la1 = 0; la2 = 0; rd1 = 0; rd2 = 0; ra1 = 0; ra2 = 0;
    repeat (3) tick();
    l_rst = 0; r_rst = 0;
    // R12: no control active after reset, so the access goes to word 0
    tag = "R12"; ldrv(1, 1, 0, 0, 0, 0, 'h55); tick();
    ldrv(1, 0, 1, 0, 0, 0, 0); tick();
    // R2 and R6: load and burst write, then burst read back
    tag = "R2"; ldrv(1, 1, 1, 0, 0, 100, 1); tick();
    tag = "R6";
    for (int i = 1; i < 5; i++) begin ldrv(1, 1, 0, 1, 0, 0, 1 + i); tick(); end
    ldrv(1, 0, 1, 0, 0, 100, 0); tick();
    for (int i = 0; i < 4; i++) begin ldrv(1, 0, 0, 1, 0, 0, 0); tick(); end
    // R3: step while loading is ignored
    tag = "R3"; ldrv(1, 1, 1, 1, 0, 200, 'h1AA); tick();
    ldrv(1, 0, 0, 0, 0, 0, 0); tick(); tick();
    // R1: clear beats load and step
    tag = "R1"; ldrv(1, 1, 1, 1, 1, 300, 'h0F0); tick();
    ldrv(1, 0, 0, 0, 0, 0, 0); tick();
    ldrv(1, 0, 1, 0, 0, 300, 0); tick();
    // R4: wrap from the top word to word 0
    tag = "R4"; ldrv(1, 1, 1, 0, 0, DEPTH - 1, 'h123); tick();
    ldrv(1, 1, 0, 1, 0, 0, 'h0AB); tick();
    ldrv(1, 0, 1, 0, 0, 0, 0); tick();
    ldrv(1, 0, 1, 0, 0, DEPTH - 1, 0); tick();
    // R5: deselected writes and reads do nothing
    tag = "R5"; ldrv(0, 1, 1, 0, 0, 100, 'h1FF); tick();
    ldrv(1, 1, 1, 0, 0, 101, 'h1EE); l_sel1 = 0; tick();
    ldrv(0, 0, 1, 0, 0, 100, 0); tick();
    ldrv(1, 0, 1, 0, 0, 100, 0); tick();
    ldrv(1, 0, 1, 0, 0, 101, 0); tick();
    // R7: output enable off hides read data
    tag = "R7"; l_oe_n = 1; ldrv(1, 0, 1, 0, 0, 102, 0); tick(); tick();
    l_oe_n = 0; tick();
    // R8 and R9: right port read modes
    tag = "R8"; rdrv(1, 1, 1, 0, 0, 400, 'h031); tick();
    rdrv(1, 1, 0, 1, 0, 0, 'h032); tick();
    rdrv(1, 0, 1, 0, 0, 400, 0); tick();
    rdrv(1, 0, 0, 1, 0, 0, 0); tick();
    tag = "R9"; r_pipe = 1; l_pipe = 1;
    rdrv(1, 0, 1, 0, 0, 400, 0); ldrv(1, 0, 1, 0, 0, 103, 0); tick();
    rdrv(1, 0, 0, 1, 0, 0, 0); ldrv(1, 0, 0, 1, 0, 0, 0); tick();
    rdrv(0, 0, 0, 0, 0, 0, 0); ldrv(0, 0, 0, 0, 0, 0, 0); tick(); tick();
    r_pipe = 0; l_pipe = 0;
    // R10: stopped right clock ignores its inputs
    tag = "R10"; r_run = 0; rdrv(1, 1, 1, 0, 0, 400, 'h0EE); repeat (4) tick();
    rdrv(1, 1, 0, 0, 1, 0, 'h0DD); tick();
    r_run = 1; rdrv(1, 0, 0, 0, 0, 0, 0); tick();
    rdrv(1, 0, 1, 0, 0, 400, 0); tick();
    // R11: same-word writes on one edge, left wins; cross read accepts old or new
    tag = "R11"; ldrv(1, 1, 1, 0, 0, 600, 'h011); rdrv(1, 1, 1, 0, 0, 600, 'h022); tick();
    ldrv(1, 0, 1, 0, 0, 600, 0); rdrv(1, 0, 1, 0, 0, 600, 0); tick();
    ldrv(1, 1, 1, 0, 0, 700, 'h033); rdrv(0, 0, 0, 0, 0, 0, 0); tick();
    ldrv(1, 1, 1, 0, 0, 700, 'h044); rdrv(1, 0, 1, 0, 0, 700, 0); tick();
    ldrv(0, 0, 0, 0, 0, 0, 0); rdrv(1, 0, 1, 0, 0, 700, 0); tick();
    rdrv(0, 0, 0, 0, 0, 0, 0); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule